// File: doc/BRIEF.md
# Four-Lane Float/Integer Converter

This block converts a four-lane vector of 32-bit words between IEEE-754 single precision and 32-bit integers, in either direction and for signed or unsigned integers. Each beat carries an opcode, a signedness bit, a mode bit choosing legacy or modern handling of NaN inputs, a broadcast bit, and the 128-bit source vector. One beat's result is registered and presented one cycle after the beat is accepted.

Float-to-int conversion truncates toward zero. Values that are out of range, and infinities, saturate to the limits of the integer type. Floats whose exponent field is zero are flushed to zero. Int-to-float conversion rounds to nearest, with ties going to even.

Both sides use a valid/ready stream. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result holds steady and no new beat is taken.

Top module: `cvt4_unit`

## Requirements
- R1: A beat is accepted on an edge where in_valid and in_ready are both high. Its result appears with out_valid high after that edge. in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R2: in_opcode 6'h2E selects float-to-int and 6'h2D selects int-to-float. A beat with any other opcode is consumed and produces no output: out_valid is low after that edge.
- R3: Float-to-int truncates toward zero. With in_signed=1 the result is two's complement; with in_signed=0 it is unsigned.
- R4: Float-to-int saturates finite values that are out of range, and infinities. Signed results saturate to 0x80000000 or 0x7FFFFFFF. Unsigned results saturate to 0xFFFFFFFF, and any negative input gives 0.
- R5: With in_legacy=1, a NaN input (exponent field all ones, fraction nonzero) converts according to its sign bit. A signed target gives 0x80000000 for a set sign and 0x7FFFFFFF for a clear sign. An unsigned target gives 0x00000000 for a set sign and 0xFFFFFFFF for a clear sign.
- R6: With in_legacy=0, a NaN input converts to 0 for both signed and unsigned targets.
- R7: A float input whose exponent field (bits 30:23) is zero converts to 0.
- R8: Int-to-float rounds to nearest, with ties to even. Integer 0 gives +0.0 (0x00000000). in_signed=1 reads the source as two's complement.
- R9: With in_bcast=1, the result of lane 0 (bits 31:0) is copied to all four lanes. With in_bcast=0, each lane i (bits 32i+31:32i) is converted on its own.
- R10: Reset drives out_valid and out_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_opcode | input | 6 | 6'h2E float-to-int, 6'h2D int-to-float |
| in_signed | input | 1 | 1 = signed integer side |
| in_legacy | input | 1 | 1 = legacy NaN handling, 0 = modern |
| in_bcast | input | 1 | 1 = copy the lane 0 result to all lanes |
| in_data | input | 128 | Source vector, lane i at bits 32i+31:32i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result vector, same lane layout |

## Verification
The hardest case to reach is a second beat that waits at the input while the first result is stalled. The stimulus lowers out_ready, lets one beat in, and then holds a different beat on the input for several cycles. It checks that in_ready stays low and that the first result stays unchanged, and only then releases out_ready so that the waiting beat replaces the first. Rounding ties are reached on purpose with integers just above 2^24, where the bit below the kept mantissa is exactly one half. Both NaN signs are driven in the same beat in each mode.

// File: rtl/cvt4_pkg.sv
package cvt4_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] OP_F2I = 6'h2E;
  localparam logic [OPC_W-1:0] OP_I2F = 6'h2D;
  localparam logic [WORD_W-1:0] S_MIN = 32'h8000_0000;
  localparam logic [WORD_W-1:0] S_MAX = 32'h7FFF_FFFF;
  localparam logic [WORD_W-1:0] U_MAX = 32'hFFFF_FFFF;

  function automatic logic [5:0] lead_zeros(input logic [WORD_W-1:0] v);
    logic [5:0] n;
    logic       hit;
    n   = '0;
    hit = 1'b0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n = n + 6'd1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/cvt4_f2i_lane.sv
module cvt4_f2i_lane
  import cvt4_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  logic              is_signed,
  input  logic              legacy,
  output logic [WORD_W-1:0] res
);
  logic                   sgn;
  logic [EXP_W-1:0]       ex;
  logic [MAN_W-1:0]       fr;
  logic                   nan_in;
  logic                   inf_in;
  logic signed [9:0]      ue;
  logic [MAN_W+WORD_W-1:0] wide;
  logic [WORD_W-1:0]      mag;

  always_comb begin
    sgn    = src[31];
    ex     = src[30:23];
    fr     = src[22:0];
    nan_in = (ex == 8'hFF) && (fr != '0);
    inf_in = (ex == 8'hFF) && (fr == '0);
    ue     = $signed({2'b00, ex}) - 10'sd127;
    wide   = {31'b0, 1'b1, fr} << ue[4:0];
    mag    = wide[MAN_W+WORD_W-1:MAN_W];
    res    = '0;
    if (nan_in) begin
      if (legacy) begin
        if (is_signed) res = sgn ? S_MIN : S_MAX;
        else           res = sgn ? '0 : U_MAX;
      end
    end else if (ex == '0) begin
      res = '0;
    end else if (is_signed) begin
      if (inf_in || ue >= 10'sd31) res = sgn ? S_MIN : S_MAX;
      else if (ue < 10'sd0)        res = '0;
      else                         res = sgn ? (~mag + 32'd1) : mag;
    end else begin
      if (sgn)                          res = '0;
      else if (inf_in || ue >= 10'sd32) res = U_MAX;
      else if (ue < 10'sd0)             res = '0;
      else                              res = mag;
    end
  end
endmodule

// File: rtl/cvt4_i2f_lane.sv
module cvt4_i2f_lane
  import cvt4_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  logic              is_signed,
  output logic [WORD_W-1:0] res
);
  logic              neg;
  logic [WORD_W-1:0] mag;
  logic [5:0]        lz;
  logic [WORD_W-1:0] norm;
  logic [EXP_W-1:0]  ex;
  logic [MAN_W-1:0]  man;
  logic              guard_b;
  logic              sticky_b;
  logic              up;
  logic [30:0]       body;

  always_comb begin
    neg      = is_signed & src[31];
    mag      = neg ? (~src + 32'd1) : src;
    lz       = lead_zeros(mag);
    norm     = mag << lz;
    ex       = 8'd158 - {2'b00, lz};
    man      = norm[30:8];
    guard_b  = norm[7];
    sticky_b = |norm[6:0];
    up       = guard_b & (sticky_b | man[0]);
    body     = {ex, man} + {30'b0, up};
    res      = (mag == '0) ? '0 : {neg, body};
  end
endmodule

// File: rtl/cvt4_lane_sel.sv
module cvt4_lane_sel
  import cvt4_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [WORD_W*LANES-1:0] per_lane,
  input  logic                    bcast,
  output logic [WORD_W*LANES-1:0] sel
);
  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign sel[g*WORD_W +: WORD_W] = bcast ? per_lane[WORD_W-1:0]
                                           : per_lane[g*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/cvt4_unit.sv
module cvt4_unit
  import cvt4_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [OPC_W-1:0]        in_opcode,
  input  logic                    in_signed,
  input  logic                    in_legacy,
  input  logic                    in_bcast,
  input  logic [WORD_W*LANES-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W*LANES-1:0] out_data
);
  localparam int VEC_W = WORD_W * LANES;

  logic             is_f2i;
  logic             known;
  logic             take;
  logic [VEC_W-1:0] f2i_vec;
  logic [VEC_W-1:0] i2f_vec;
  logic [VEC_W-1:0] pick_vec;
  logic [VEC_W-1:0] sel_vec;

  assign is_f2i   = (in_opcode == OP_F2I);
  assign known    = is_f2i || (in_opcode == OP_I2F);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cvt4_f2i_lane u_f2i (
      .src       (in_data[g*WORD_W +: WORD_W]),
      .is_signed (in_signed),
      .legacy    (in_legacy),
      .res       (f2i_vec[g*WORD_W +: WORD_W])
    );
    cvt4_i2f_lane u_i2f (
      .src       (in_data[g*WORD_W +: WORD_W]),
      .is_signed (in_signed),
      .res       (i2f_vec[g*WORD_W +: WORD_W])
    );
  end

  assign pick_vec = is_f2i ? f2i_vec : i2f_vec;

  cvt4_lane_sel #(.LANES(LANES)) u_sel (
    .per_lane (pick_vec),
    .bcast    (in_bcast),
    .sel      (sel_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= known;
      if (known) out_data <= sel_vec;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cvt4_unit_chk.sv
module cvt4_unit_chk
  import cvt4_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [OPC_W-1:0]        in_opcode,
  input logic                    in_legacy,
  input logic                    in_bcast,
  input logic [WORD_W*LANES-1:0] in_data,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [WORD_W*LANES-1:0] out_data
);
  logic known_c;
  logic bc_q;
  logic nan0_q;
  logic lane0_nan;

  assign known_c   = (in_opcode == OP_F2I) || (in_opcode == OP_I2F);
  assign lane0_nan = (in_data[30:23] == 8'hFF) && (in_data[22:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q   <= 1'b0;
      nan0_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      bc_q   <= in_bcast && known_c;
      nan0_q <= (in_opcode == OP_F2I) && !in_legacy && lane0_nan;
    end
  end

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && known_c) |=> out_valid);

  // R2
  unknown_op_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !known_c) |=> !out_valid);

  // R9
  bcast_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bc_q) |-> (out_data == {LANES{out_data[WORD_W-1:0]}}));

  // R6
  modern_nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nan0_q) |-> (out_data[WORD_W-1:0] == '0));
endmodule

bind cvt4_unit cvt4_unit_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_opcode (in_opcode),
  .in_legacy (in_legacy),
  .in_bcast  (in_bcast),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/cvt4_unit_tb.sv
module cvt4_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [5:0]   in_opcode = '0;
  logic         in_signed = 1'b0;
  logic         in_legacy = 1'b0;
  logic         in_bcast = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  int           tests = 0;
  int           fails = 0;
  bit           done = 1'b0;

  localparam logic [5:0] F2I = 6'h2E;
  localparam logic [5:0] I2F = 6'h2D;

  always #2.5 clk = ~clk;

  cvt4_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_signed(in_signed), .in_legacy(in_legacy),
    .in_bcast(in_bcast), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic [5:0] op, input logic sg,
                      input logic lg, input logic bc, input logic [127:0] d,
                      input logic [127:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_signed = sg; in_legacy = lg;
    in_bcast = bc; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {127'b0, out_valid}, 128'd1);
    chk(req, out_data, exp);
  endtask

  task automatic t_reset;
    chk("R10 reset valid", {127'b0, out_valid}, 128'd0);
    chk("R10 reset data", out_data, 128'd0);
    chk("R1 reset ready", {127'b0, in_ready}, 128'd1);
  endtask

  task automatic t_f2i_trunc;
    send("R3 signed trunc", F2I, 1'b1, 1'b0, 1'b0,
         {32'h3F000000, 32'h42C90000, 32'hC0700000, 32'h40700000},
         {32'h0, 32'd100, 32'hFFFFFFFD, 32'd3});
  endtask

  task automatic t_f2i_sat;
    send("R4 signed sat", F2I, 1'b1, 1'b0, 1'b0,
         {32'h7F800000, 32'hFF800000, 32'hCF000000, 32'h4F000000},
         {32'h7FFFFFFF, 32'h80000000, 32'h80000000, 32'h7FFFFFFF});
    send("R7 flush", F2I, 1'b1, 1'b0, 1'b0,
         {32'h80400000, 32'h00000001, 32'h00400000, 32'h007FFFFF},
         128'd0);
  endtask

  task automatic t_f2i_unsigned;
    send("R4 unsigned", F2I, 1'b0, 1'b0, 1'b0,
         {32'h42C90000, 32'h4F800000, 32'hC0A00000, 32'h4F000000},
         {32'd100, 32'hFFFFFFFF, 32'h0, 32'h80000000});
  endtask

  task automatic t_nan_modern;
    send("R6 signed", F2I, 1'b1, 1'b0, 1'b0,
         {32'hFFFFFFFF, 32'h7F800001, 32'hFFC00000, 32'h7FC00000}, 128'd0);
    send("R6 unsigned", F2I, 1'b0, 1'b0, 1'b0,
         {32'hFFFFFFFF, 32'h7F800001, 32'hFFC00000, 32'h7FC00000}, 128'd0);
  endtask

  task automatic t_nan_legacy;
    send("R5 signed", F2I, 1'b1, 1'b1, 1'b0,
         {32'hFFFFFFFF, 32'h7F800001, 32'hFFC00000, 32'h7FC00000},
         {32'h80000000, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF});
    send("R5 unsigned", F2I, 1'b0, 1'b1, 1'b0,
         {32'hFFFFFFFF, 32'h7F800001, 32'hFFC00000, 32'h7FC00000},
         {32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF});
  endtask

  task automatic t_bcast;
    send("R9 bcast f2i", F2I, 1'b1, 1'b1, 1'b1,
         {32'h7FC00000, 32'hC0700000, 32'h3F800000, 32'h41200000},
         {4{32'd10}});
    send("R9 bcast i2f", I2F, 1'b1, 1'b0, 1'b1,
         {32'd7, 32'hFFFFFFFF, 32'd0, 32'd5}, {4{32'h40A00000}});
  endtask

  task automatic t_i2f;
    send("R8 signed", I2F, 1'b1, 1'b0, 1'b0,
         {32'h80000000, 32'h0, 32'hFFFFFFFF, 32'd1},
         {32'hCF000000, 32'h0, 32'hBF800000, 32'h3F800000});
    send("R8 unsigned tie", I2F, 1'b0, 1'b0, 1'b0,
         {32'h80000000, 32'h01000003, 32'h01000001, 32'hFFFFFFFF},
         {32'h4F000000, 32'h4B800002, 32'h4B800000, 32'h4F800000});
  endtask

  task automatic t_unknown_op;
    @(negedge clk);
    in_valid = 1'b1; in_opcode = 6'h00; in_data = {4{32'h3F800000}};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 unknown opcode", {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_opcode = F2I; in_signed = 1'b1; in_legacy = 1'b0;
    in_bcast = 1'b0; in_data = {4{32'h40700000}};
    @(negedge clk);
    in_opcode = I2F; in_data = {4{32'd1}};
    for (int k = 0; k < 3; k++) begin
      chk("R1 stall ready", {127'b0, in_ready}, 128'd0);
      chk("R1 stall valid", {127'b0, out_valid}, 128'd1);
      chk("R1 stall data", out_data, {4{32'd3}});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 drain valid", {127'b0, out_valid}, 128'd1);
    chk("R1 drain data", out_data, {4{32'h3F800000}});
    @(negedge clk);
    chk("R1 empty", {127'b0, out_valid}, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_f2i_trunc();
    t_f2i_sat();
    t_f2i_unsigned();
    t_nan_modern();
    t_nan_legacy();
    t_bcast();
    t_i2f();
    t_unknown_op();
    t_backpressure();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule